// File: doc/BRIEF.md
# Reservation Monitor for Paired Reserved Loads and Conditional Stores

This block keeps one reservation for each hardware thread and decides whether a conditional store may write memory. A reserved load records the granule it touched and the exact bytes it read. From then on, every store that becomes globally visible is shown to the block on a snoop port. If that store comes from another thread and writes any reserved byte, the reservation of the reserving thread is dropped. Stores from the reserving thread itself leave its reservation in place.

When a conditional store arrives, the block compares it with the reservation of the issuing thread. One cycle later it returns a single result: 0 means success and 1 means failure. In the same cycle it raises a write enable, and only when the result is success. A failed conditional store therefore never reaches memory.

Every conditional store attempt clears the reservation of its own thread, whether it succeeds or fails. A newer reserved load from the same thread replaces the older reservation.

Top module: `rsv_monitor`

## Requirements
- R1: After reset no thread holds a reservation and `sc_resp_valid` and `sc_wr_en` are 0. A conditional store issued right after reset fails.
- R2: A reserved load followed by a conditional store from the same thread, with the same address and size and no intervening foreign store, returns `sc_resp_fail` = 0 with `sc_wr_en` = 1.
- R3: A conditional store from a thread that holds no reservation returns `sc_resp_fail` = 1 with `sc_wr_en` = 0. A reservation held by another thread does not count.
- R4: A snooped store from a different thread that writes at least one reserved byte of the reserved granule drops the reservation, and the next conditional store fails.
- R5: With `BYTE_EXACT` = 1, a foreign store into the reserved granule that writes none of the reserved bytes leaves the reservation intact. Byte b of `snp_mask` is address offset b within the granule.
- R6: A snooped store from the reserving thread itself never drops that thread's reservation, even if it writes every reserved byte.
- R7: Every conditional store clears the issuing thread's reservation, so a second conditional store without a new reserved load fails.
- R8: A new reserved load from a thread replaces its earlier reservation. A conditional store to the old address fails and one to the new address succeeds.
- R9: A conditional store whose granule or byte set differs from the reservation fails. This covers a different size and a different offset.
- R10: A reserved load that is not naturally aligned, or that is wider than the granule, installs nothing and drops any existing reservation of its thread.
- R11: Within one cycle the snoop is applied first, then the conditional store, and the reserved load last. So a foreign overlapping store in the same cycle as a conditional store makes it fail, and a reserved load in the same cycle as a foreign overlapping store keeps its new reservation.
- R12: The response appears exactly one cycle after `sc_valid`, for one cycle, and `sc_wr_en` is high only when the response is a success.
- R13: Reservations of different threads are independent. A conditional store from one thread does not clear another thread's reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_valid | input | 1 | Reserved load request |
| lr_tid | input | TID_W | Thread of the reserved load |
| lr_addr | input | ADDR_W | Byte address of the reserved load |
| lr_size | input | SIZE_W | log2 of the access size in bytes |
| sc_valid | input | 1 | Conditional store request |
| sc_tid | input | TID_W | Thread of the conditional store |
| sc_addr | input | ADDR_W | Byte address of the conditional store |
| sc_size | input | SIZE_W | log2 of the access size in bytes |
| snp_valid | input | 1 | A store became globally visible |
| snp_tid | input | TID_W | Thread that issued the visible store |
| snp_gran | input | ADDR_W-OFF_W | Granule address of the visible store |
| snp_mask | input | GRAN_BYTES | Bytes written within the granule, bit b = offset b |
| sc_resp_valid | output | 1 | Conditional store result valid |
| sc_resp_fail | output | 1 | 0 = success, 1 = failure |
| sc_wr_en | output | 1 | Permit the conditional store's memory write |

## Verification
The embedded assertions check a set of per-cycle rules on every cycle. Each conditional store is answered exactly one cycle later, and the write enable appears only with a success. Any attempt empties its thread's slot. A misaligned reserved load leaves the slot empty. A foreign store onto a reserved byte empties the slot, while a store from the same thread leaves the slot unchanged.

Some properties hold only across several requests, so only the bench scenarios show them:
- whether a reservation survives a foreign store to neighbouring bytes;
- replacement by a newer reserved load;
- the size and offset match checks;
- independence between threads;
- the order in which snoop, conditional store and reserved load are applied within one cycle.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
   // Result encoding on sc_resp_fail
   localparam logic SC_PASS = 1'b0;
   localparam logic SC_FAIL = 1'b1;

   // Width of a thread index for a given thread count
   function automatic int tid_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rsv_mask_gen.sv
module rsv_mask_gen #(
   parameter int ADDR_W     = 32,
   parameter int GRAN_BYTES = 8,
   parameter int SIZE_W     = 2,
   localparam int OFF_W     = $clog2(GRAN_BYTES),
   localparam int GRAN_W    = ADDR_W - OFF_W
) (
   input  logic [ADDR_W-1:0]     addr,
   input  logic [SIZE_W-1:0]     size,
   output logic [GRAN_W-1:0]     gran,
   output logic [GRAN_BYTES-1:0] mask
);
   int  len;
   int  off;
   logic legal;

   assign gran = addr[ADDR_W-1:OFF_W];

   // Natural alignment and fit within one granule, else an empty mask
   always_comb begin
      len   = 1 << size;
      off   = int'(addr[OFF_W-1:0]);
      legal = (len <= GRAN_BYTES) && ((off % len) == 0);
      for (int b = 0; b < GRAN_BYTES; b++)
         mask[b] = legal && (b >= off) && (b < off + len);
   end
endmodule

// File: rtl/rsv_overlap.sv
module rsv_overlap #(
   parameter int GRAN_W     = 29,
   parameter int GRAN_BYTES = 8,
   parameter bit BYTE_EXACT = 1'b1
) (
   input  logic [GRAN_W-1:0]     gran_a,
   input  logic [GRAN_BYTES-1:0] mask_a,
   input  logic [GRAN_W-1:0]     gran_b,
   input  logic [GRAN_BYTES-1:0] mask_b,
   output logic                  hit
);
   generate
      if (BYTE_EXACT) begin : g_byte
         // Conflict only when a common byte is written
         assign hit = (gran_a == gran_b) && |(mask_a & mask_b);
      end else begin : g_gran
         // Coarse variant: any write into the granule conflicts
         assign hit = (gran_a == gran_b) && (|mask_a) && (|mask_b);
      end
   endgenerate
endmodule

// File: rtl/rsv_slot.sv
module rsv_slot #(
   parameter int GRAN_W     = 29,
   parameter int GRAN_BYTES = 8,
   parameter bit BYTE_EXACT = 1'b1,
   parameter int TID_W      = 2,
   parameter int MY_ID      = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  lr_hit,
   input  logic [GRAN_W-1:0]     lr_gran,
   input  logic [GRAN_BYTES-1:0] lr_mask,
   input  logic                  sc_hit,
   input  logic                  snp_valid,
   input  logic [TID_W-1:0]      snp_tid,
   input  logic [GRAN_W-1:0]     snp_gran,
   input  logic [GRAN_BYTES-1:0] snp_mask,
   output logic                  rsv_valid,
   output logic [GRAN_W-1:0]     rsv_gran,
   output logic [GRAN_BYTES-1:0] rsv_mask,
   output logic                  kill_now
);
   logic foreign;
   logic overlap;

   assign foreign = snp_tid != TID_W'(MY_ID);

   rsv_overlap #(
      .GRAN_W    (GRAN_W),
      .GRAN_BYTES(GRAN_BYTES),
      .BYTE_EXACT(BYTE_EXACT)
   ) u_ovl (
      .gran_a(rsv_gran),
      .mask_a(rsv_mask),
      .gran_b(snp_gran),
      .mask_b(snp_mask),
      .hit   (overlap)
   );

   assign kill_now = rsv_valid && snp_valid && foreign && overlap;

   // Order inside a cycle: snoop kill, then SC clear, then LR install
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsv_valid <= 1'b0;
         rsv_gran  <= '0;
         rsv_mask  <= '0;
      end else if (lr_hit) begin
         rsv_valid <= |lr_mask;
         rsv_gran  <= lr_gran;
         rsv_mask  <= lr_mask;
      end else if (sc_hit || kill_now) begin
         rsv_valid <= 1'b0;
      end
   end

   assert_sc_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sc_hit && !lr_hit |=> !rsv_valid);

   assert_bad_lr_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lr_hit && !(|lr_mask) |=> !rsv_valid);

   assert_foreign_kill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_valid && snp_valid && (snp_tid != TID_W'(MY_ID)) && (snp_gran == rsv_gran)
      && |(snp_mask & rsv_mask) && !lr_hit |=> !rsv_valid);

   assert_own_store_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_valid && snp_valid && (snp_tid == TID_W'(MY_ID)) && !lr_hit && !sc_hit
      |=> rsv_valid && $stable(rsv_gran) && $stable(rsv_mask));
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
   parameter int NUM_THREADS = 4,
   parameter int ADDR_W      = 32,
   parameter int GRAN_BYTES  = 8,
   parameter int SIZE_W      = 2,
   parameter bit BYTE_EXACT  = 1'b1,
   localparam int OFF_W      = $clog2(GRAN_BYTES),
   localparam int GRAN_W     = ADDR_W - OFF_W,
   localparam int TID_W      = rsv_pkg::tid_width(NUM_THREADS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  lr_valid,
   input  logic [TID_W-1:0]      lr_tid,
   input  logic [ADDR_W-1:0]     lr_addr,
   input  logic [SIZE_W-1:0]     lr_size,
   input  logic                  sc_valid,
   input  logic [TID_W-1:0]      sc_tid,
   input  logic [ADDR_W-1:0]     sc_addr,
   input  logic [SIZE_W-1:0]     sc_size,
   input  logic                  snp_valid,
   input  logic [TID_W-1:0]      snp_tid,
   input  logic [GRAN_W-1:0]     snp_gran,
   input  logic [GRAN_BYTES-1:0] snp_mask,
   output logic                  sc_resp_valid,
   output logic                  sc_resp_fail,
   output logic                  sc_wr_en
);
   import rsv_pkg::*;

   // Elaboration-time parameter checks
   if (GRAN_BYTES < 2 || (GRAN_BYTES & (GRAN_BYTES - 1)) != 0) begin : g_bad_gran
      $error("GRAN_BYTES must be a power of two, at least 2");
   end
   if (NUM_THREADS < 1) begin : g_bad_thr
      $error("NUM_THREADS must be at least 1");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed the granule offset width");
   end

   logic [GRAN_W-1:0]     lr_gran, sc_gran;
   logic [GRAN_BYTES-1:0] lr_mask, sc_mask;

   rsv_mask_gen #(.ADDR_W(ADDR_W), .GRAN_BYTES(GRAN_BYTES), .SIZE_W(SIZE_W)) u_lr_mask (
      .addr(lr_addr), .size(lr_size), .gran(lr_gran), .mask(lr_mask));

   rsv_mask_gen #(.ADDR_W(ADDR_W), .GRAN_BYTES(GRAN_BYTES), .SIZE_W(SIZE_W)) u_sc_mask (
      .addr(sc_addr), .size(sc_size), .gran(sc_gran), .mask(sc_mask));

   logic                  rv   [NUM_THREADS];
   logic [GRAN_W-1:0]     rg   [NUM_THREADS];
   logic [GRAN_BYTES-1:0] rm   [NUM_THREADS];
   logic                  kill [NUM_THREADS];

   for (genvar i = 0; i < NUM_THREADS; i++) begin : g_slot
      rsv_slot #(
         .GRAN_W    (GRAN_W),
         .GRAN_BYTES(GRAN_BYTES),
         .BYTE_EXACT(BYTE_EXACT),
         .TID_W     (TID_W),
         .MY_ID     (i)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .lr_hit   (lr_valid && (lr_tid == TID_W'(i))),
         .lr_gran  (lr_gran),
         .lr_mask  (lr_mask),
         .sc_hit   (sc_valid && (sc_tid == TID_W'(i))),
         .snp_valid(snp_valid),
         .snp_tid  (snp_tid),
         .snp_gran (snp_gran),
         .snp_mask (snp_mask),
         .rsv_valid(rv[i]),
         .rsv_gran (rg[i]),
         .rsv_mask (rm[i]),
         .kill_now (kill[i])
      );
   end

   // Pairing decision against the issuing thread's slot
   logic pass;
   always_comb begin
      pass = 1'b0;
      for (int i = 0; i < NUM_THREADS; i++)
         if (sc_tid == TID_W'(i))
            pass = rv[i] && !kill[i] && (rg[i] == sc_gran)
                   && (rm[i] == sc_mask) && (|sc_mask);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sc_resp_valid <= 1'b0;
         sc_resp_fail  <= SC_PASS;
         sc_wr_en      <= 1'b0;
      end else begin
         sc_resp_valid <= sc_valid;
         sc_resp_fail  <= sc_valid && !pass;
         sc_wr_en      <= sc_valid && pass;
      end
   end

   assert_resp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sc_valid |=> sc_resp_valid);

   assert_no_spurious_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !sc_valid |=> !sc_resp_valid && !sc_wr_en);

   assert_wr_only_success_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sc_wr_en |-> sc_resp_valid && (sc_resp_fail == SC_PASS));

   assert_fail_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sc_resp_valid && sc_resp_fail |-> !sc_wr_en);
endmodule

// File: tb/rsv_monitor_test.sv
`timescale 1ns/100ps
module rsv_monitor_test;
   localparam int NT = 4, AW = 32, GB = 8, SW = 2, TW = 2, GW = 29;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lr_valid = 0, sc_valid = 0, snp_valid = 0;
   logic [TW-1:0] lr_tid = 0, sc_tid = 0, snp_tid = 0;
   logic [AW-1:0] lr_addr = 0, sc_addr = 0;
   logic [SW-1:0] lr_size = 0, sc_size = 0;
   logic [GW-1:0] snp_gran = 0;
   logic [GB-1:0] snp_mask = 0;
   logic sc_resp_valid, sc_resp_fail, sc_wr_en;

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;

   bit    q_fail[$];
   int    q_cyc[$];
   string q_tag[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rsv_monitor uut (
      .clk(clk), .rst_n(rst_n),
      .lr_valid(lr_valid), .lr_tid(lr_tid), .lr_addr(lr_addr), .lr_size(lr_size),
      .sc_valid(sc_valid), .sc_tid(sc_tid), .sc_addr(sc_addr), .sc_size(sc_size),
      .snp_valid(snp_valid), .snp_tid(snp_tid), .snp_gran(snp_gran), .snp_mask(snp_mask),
      .sc_resp_valid(sc_resp_valid), .sc_resp_fail(sc_resp_fail), .sc_wr_en(sc_wr_en));

   // Monitor: pops expected results as responses appear
   always @(negedge clk) begin
      if (rst_n && sc_resp_valid) begin
         checks++;
         if (q_fail.size() == 0) begin
            fails++;
            $display("FAIL R12: unexpected response, actual valid=1 expected valid=0");
         end else begin
            automatic bit    ef = q_fail.pop_front();
            automatic int    ec = q_cyc.pop_front();
            automatic string et = q_tag.pop_front();
            if (sc_resp_fail !== ef || sc_wr_en !== !ef || cyc != ec) begin
               fails++;
               $display("FAIL %s: actual fail=%b wr=%b cyc=%0d expected fail=%b wr=%b cyc=%0d",
                        et, sc_resp_fail, sc_wr_en, cyc, ef, !ef, ec);
            end
         end
      end else if (rst_n && q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
         checks++;
         fails++;
         $display("FAIL R12: missing response, actual valid=0 expected valid=1");
         void'(q_fail.pop_front());
         void'(q_cyc.pop_front());
         void'(q_tag.pop_front());
      end
   end

   // Driver: one cycle of stimulus, starting at a falling edge
   task automatic step(input bit lv, input int lt, input int la, input int ls,
                       input bit sv, input int st, input int sa, input int ss,
                       input bit nv, input int nt, input int ng, input int nm,
                       input bit ef, input string tag);
      lr_valid = lv; lr_tid = TW'(lt); lr_addr = AW'(la); lr_size = SW'(ls);
      sc_valid = sv; sc_tid = TW'(st); sc_addr = AW'(sa); sc_size = SW'(ss);
      snp_valid = nv; snp_tid = TW'(nt); snp_gran = GW'(ng); snp_mask = GB'(nm);
      if (sv) begin
         q_fail.push_back(ef);
         q_cyc.push_back(cyc + 1);
         q_tag.push_back(tag);
      end
      @(negedge clk);
      lr_valid = 0; sc_valid = 0; snp_valid = 0;
   endtask

   task automatic lr(input int t, input int a, input int s);
      step(1, t, a, s, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
   endtask

   task automatic sc(input int t, input int a, input int s, input bit ef, input string tag);
      step(0, 0, 0, 0, 1, t, a, s, 0, 0, 0, 0, ef, tag);
   endtask

   task automatic snp(input int t, input int g, input int m);
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, t, g, m, 0, "");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (sc_resp_valid !== 1'b0 || sc_wr_en !== 1'b0) begin
         fails++;
         $display("FAIL R1: reset outputs actual %b%b expected 00", sc_resp_valid, sc_wr_en);
      end
      rst_n = 1;
      @(negedge clk);
      sc(0, 'h100, 2, 1, "R1");                        // no reservation after reset
      lr(0, 'h100, 2); sc(0, 'h100, 2, 0, "R2");       // plain pair
      sc(0, 'h100, 2, 1, "R7");                        // attempt cleared it
      lr(1, 'h200, 3); sc(2, 'h200, 3, 1, "R3");       // other thread's reservation
      sc(1, 'h200, 3, 0, "R13");                       // untouched by thread 2
      lr(0, 'h100, 2); snp(1, 'h20, 'h08);             // foreign store on byte 3
      sc(0, 'h100, 2, 1, "R4");
      lr(0, 'h104, 2); snp(1, 'h20, 'h0F);             // foreign store, other bytes
      sc(0, 'h104, 2, 0, "R5");
      lr(0, 'h100, 3); snp(0, 'h20, 'hFF);             // own store, all bytes
      sc(0, 'h100, 3, 0, "R6");
      lr(0, 'h100, 2); lr(0, 'h300, 2); sc(0, 'h100, 2, 1, "R8");
      lr(0, 'h100, 2); lr(0, 'h300, 2); sc(0, 'h300, 2, 0, "R8");
      lr(3, 'h100, 2); sc(3, 'h100, 1, 1, "R9");       // size differs
      lr(3, 'h100, 2); sc(3, 'h104, 2, 1, "R9");       // offset differs
      lr(2, 'h100, 2); lr(2, 'h102, 2); sc(2, 'h100, 2, 1, "R10");
      lr(2, 'h102, 2); sc(2, 'h102, 2, 1, "R10");
      lr(1, 'h100, 2);                                 // SC and foreign snoop together
      step(0, 0, 0, 0, 1, 1, 'h100, 2, 1, 0, 'h20, 'h01, 1, "R11");
      step(1, 1, 'h100, 2, 0, 0, 0, 0, 1, 0, 'h20, 'h01, 0, "");  // LR and snoop together
      sc(1, 'h100, 2, 0, "R11");
      repeat (3) @(negedge clk);
      checks++;
      if (q_fail.size() != 0) begin
         fails++;
         $display("FAIL R12: pending responses actual %0d expected 0", q_fail.size());
      end
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            fails++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule